// File: doc/BRIEF.md
# Resource-driven flash request scheduler

This block sits between the stage that splits host I/O requests into flash-unit memory requests and the per-chip flash controllers. Every memory request it receives already names its target chip, die and plane, its operation and the tag of the host I/O request it belongs to. The upstream stage marks the final memory request of each host request. Accepted requests wait in a small shared pool.

Requests leave the pool in the order that the chips become free, not in the order in which they arrived. Every chip whose ready flag is high and which has no unacknowledged command receives the oldest pooled request that targets it. All such chips are served in the same cycle, so a busy chip never holds back work for the others.

A per-tag counter tracks requests that are pooled or in flight. When the counter of a tag whose final request has been accepted drops to zero, the block reports that host request as finished. Completions are reported one per cycle, and a round-robin pointer chooses among the tags that are waiting.

Top module: `flash_rsched`

## Requirements
- R1: After reset, `in_ready` is 1 and `cmd_valid` and `done_valid` are all 0.
- R2: The pool holds 16 requests. `in_ready` is 1 while fewer than 16 are held and 0 when 16 are held. A request offered while `in_ready` is 0 is dropped and is never dispatched.
- R3: Suppose request X is accepted at a clock edge, its chip c has `chip_rdy[c]`=1, c holds no unacknowledged command and no older request for c is pooled. In the cycle after that edge, `cmd_valid[c]` is 1 and `cmd_die[c]`, `cmd_plane[c]`, `cmd_op[c]` and `cmd_tag[c]` equal the fields of X. A command is taken at the clock edge where its `cmd_valid` is 1. Operation codes: 0 read, 1 program, 2 erase.
- R4: `cmd_valid[c]` is 0 in every cycle where `chip_rdy[c]` is 0.
- R5: Requests for a ready chip are dispatched even while older requests for a busy chip remain pooled.
- R6: When several pooled requests target the same chip, they are dispatched in the order they were accepted.
- R7: After a chip takes a command, it gets no further command until `chip_ack[c]` is sampled high. A `chip_ack[c]` pulse while chip c holds no command has no effect.
- R8: A tag's counter reaches zero when the acknowledgement of its last outstanding request is sampled at some clock edge, provided the request flagged by `in_last` has been accepted. In the cycle after that edge, `done_valid` is 1 with `done_tag` equal to the tag, for one cycle. It is not reported earlier.
- R9: Tags that finish at the same edge are reported in consecutive cycles, each exactly once, picked round-robin.
- R10: Several chips receive commands in the same cycle when each of them is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming memory request is offered |
| in_ready | output | 1 | Pool has a free entry |
| in_chip | input | 2 | Target chip index (channel times ways plus way) |
| in_die | input | 1 | Target die |
| in_plane | input | 2 | Target plane |
| in_op | input | 2 | Operation code |
| in_tag | input | 4 | Host I/O request tag |
| in_last | input | 1 | Final memory request of this tag |
| chip_rdy | input | 4 | Per-chip ready (1) / busy (0) flag |
| chip_ack | input | 4 | Per-chip completion of its current command |
| cmd_valid | output | 4 | Per-chip command strobe |
| cmd_die | output | 4 x 1 | Per-chip command die |
| cmd_plane | output | 4 x 2 | Per-chip command plane |
| cmd_op | output | 4 x 2 | Per-chip command operation |
| cmd_tag | output | 4 x 4 | Per-chip command tag |
| done_valid | output | 1 | Host request completion strobe |
| done_tag | output | 4 | Tag of the completed host request |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is dispatch on several chips, which shares its cycles with the release of pool entries while the pool is full. The second is completion, where acknowledgements from three chips land at one edge and finish three different tags together. The first pair is provoked by filling the pool with all chips busy, offering a seventeenth request and then raising every ready flag at once. It is judged by counting exactly sixteen dispatches carrying only the pooled tag. The second pair is judged by requiring three back-to-back completion pulses that together name each of the three tags once.

// File: rtl/frs_pkg.sv
package frs_pkg;

    localparam int NUM_CH         = 2;
    localparam int WAYS_PER_CH    = 2;
    localparam int NUM_CHIPS      = NUM_CH * WAYS_PER_CH;
    localparam int DIES_PER_CHIP  = 2;
    localparam int PLANES_PER_DIE = 4;
    localparam int POOL_DEPTH     = 16;
    localparam int NUM_TAGS       = 16;

    localparam int CHIP_W     = $clog2(NUM_CHIPS);
    localparam int DIE_W      = $clog2(DIES_PER_CHIP);
    localparam int PLANE_W    = $clog2(PLANES_PER_DIE);
    localparam int TAG_W      = $clog2(NUM_TAGS);
    localparam int POOL_IDX_W = $clog2(POOL_DEPTH);
    localparam int CNT_W      = $clog2(POOL_DEPTH + NUM_CHIPS + 1);

    typedef logic [POOL_DEPTH-1:0]                  pool_vec_t;
    typedef logic [POOL_DEPTH-1:0][POOL_DEPTH-1:0]  age_mat_t;
    typedef logic [NUM_TAGS-1:0]                    tag_vec_t;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_PROG  = 2'd1,
        OP_ERASE = 2'd2,
        OP_RSVD  = 2'd3
    } flash_op_e;

    typedef struct packed {
        logic [CHIP_W-1:0]  chip;
        logic [DIE_W-1:0]   die;
        logic [PLANE_W-1:0] plane;
        flash_op_e          op;
        logic [TAG_W-1:0]   tag;
    } mreq_t;

    // Lowest-numbered empty pool slot.
    function automatic logic [POOL_IDX_W-1:0] first_free(input pool_vec_t v);
        logic [POOL_IDX_W-1:0] idx;
        logic                  hit;
        idx = '0;
        hit = 1'b0;
        for (int i = 0; i < POOL_DEPTH; i++) begin
            if (!hit && !v[i]) begin
                idx = POOL_IDX_W'(i);
                hit = 1'b1;
            end
        end
        return idx;
    endfunction

    // Entry of cand that no other member of cand predates; older[j][i] = j before i.
    function automatic pool_vec_t oldest_of(input pool_vec_t cand, input age_mat_t older);
        pool_vec_t sel;
        logic      blocked;
        for (int i = 0; i < POOL_DEPTH; i++) begin
            blocked = 1'b0;
            for (int j = 0; j < POOL_DEPTH; j++) begin
                if (cand[j] && older[j][i]) blocked = 1'b1;
            end
            sel[i] = cand[i] && !blocked;
        end
        return sel;
    endfunction

    // One-hot grant: first requester at or after ptr, wrapping.
    function automatic tag_vec_t rr_pick(input tag_vec_t req, input logic [TAG_W-1:0] ptr);
        tag_vec_t g;
        logic     hit;
        int       idx;
        g   = '0;
        hit = 1'b0;
        for (int k = 0; k < NUM_TAGS; k++) begin
            idx = (int'(ptr) + k) % NUM_TAGS;
            if (!hit && req[idx]) begin
                g[idx] = 1'b1;
                hit    = 1'b1;
            end
        end
        return g;
    endfunction

    function automatic logic [TAG_W-1:0] tag_index(input tag_vec_t oh);
        logic [TAG_W-1:0] idx;
        idx = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            if (oh[i]) idx = TAG_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/frs_req_pool.sv
module frs_req_pool
    import frs_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  mreq_t                      wr_req,
    input  pool_vec_t                  free_mask,
    output pool_vec_t                  valid,
    output mreq_t [POOL_DEPTH-1:0]     entries,
    output age_mat_t                   older,
    output logic                       has_room
);

    logic [POOL_IDX_W-1:0] wr_idx;

    assign has_room = ~&valid;
    assign wr_idx   = first_free(valid);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= '0;
            older <= '0;
        end else begin
            for (int i = 0; i < POOL_DEPTH; i++) begin
                if (free_mask[i]) valid[i] <= 1'b0;
            end
            if (wr_en) begin
                valid[wr_idx] <= 1'b1;
                for (int j = 0; j < POOL_DEPTH; j++) begin
                    older[wr_idx][j] <= 1'b0;
                    older[j][wr_idx] <= valid[j] & ~free_mask[j];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) entries[wr_idx] <= wr_req;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !valid[wr_idx]); // R2

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid[$past(wr_idx)]); // R2

    AST_FREE_HELD: assert property (@(posedge clk) disable iff (rst)
        (free_mask & ~valid) == '0); // R3

endmodule

// File: rtl/frs_chip_dispatch.sv
module frs_chip_dispatch
    import frs_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  pool_vec_t                          valid,
    input  mreq_t [POOL_DEPTH-1:0]             entries,
    input  age_mat_t                           older,
    input  logic [NUM_CHIPS-1:0]               chip_rdy,
    input  logic [NUM_CHIPS-1:0]               chip_ack,
    output logic [NUM_CHIPS-1:0]               cmd_valid,
    output mreq_t [NUM_CHIPS-1:0]              cmd_req,
    output pool_vec_t                          free_mask,
    output logic [NUM_CHIPS-1:0]               ack_hit,
    output logic [NUM_CHIPS-1:0][TAG_W-1:0]    ack_tag
);

    logic [NUM_CHIPS-1:0]             inflight;
    logic [NUM_CHIPS-1:0][TAG_W-1:0]  inflight_tag;
    pool_vec_t [NUM_CHIPS-1:0]        cand;
    pool_vec_t [NUM_CHIPS-1:0]        grant;
    logic [NUM_CHIPS-1:0]             elig;

    genvar c;
    generate
        for (c = 0; c < NUM_CHIPS; c++) begin : g_chip
            always_comb begin
                for (int i = 0; i < POOL_DEPTH; i++) begin
                    cand[c][i] = valid[i] && (entries[i].chip == CHIP_W'(c));
                end
            end

            assign elig[c]      = chip_rdy[c] && !inflight[c];
            assign grant[c]     = elig[c] ? oldest_of(cand[c], older) : '0;
            assign cmd_valid[c] = elig[c] && (|cand[c]);
            assign ack_hit[c]   = chip_ack[c] && inflight[c];
            assign ack_tag[c]   = inflight_tag[c];

            always_comb begin
                cmd_req[c] = '0;
                for (int i = 0; i < POOL_DEPTH; i++) begin
                    if (grant[c][i]) cmd_req[c] = entries[i];
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    inflight[c]     <= 1'b0;
                    inflight_tag[c] <= '0;
                end else if (cmd_valid[c]) begin
                    inflight[c]     <= 1'b1;
                    inflight_tag[c] <= cmd_req[c].tag;
                end else if (ack_hit[c]) begin
                    inflight[c]     <= 1'b0;
                end
            end

            AST_LOCK_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
                cmd_valid[c] |=> !cmd_valid[c]); // R7

            AST_SINGLE_PICK: assert property (@(posedge clk) disable iff (rst)
                cmd_valid[c] |-> ($countones(grant[c]) == 1)); // R6
        end
    endgenerate

    always_comb begin
        free_mask = '0;
        for (int k = 0; k < NUM_CHIPS; k++) free_mask = free_mask | grant[k];
    end

endmodule

// File: rtl/frs_tag_tracker.sv
module frs_tag_tracker
    import frs_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               acc_en,
    input  logic [TAG_W-1:0]                   acc_tag,
    input  logic                               acc_last,
    input  logic [NUM_CHIPS-1:0]               ack_hit,
    input  logic [NUM_CHIPS-1:0][TAG_W-1:0]    ack_tag,
    output logic                               done_valid,
    output logic [TAG_W-1:0]                   done_tag
);

    logic [NUM_TAGS-1:0][CNT_W-1:0] cnt;
    logic [NUM_TAGS-1:0][CNT_W-1:0] cnt_nx;
    logic [NUM_TAGS-1:0][CNT_W-1:0] dec_n;
    tag_vec_t                       last_seen;
    tag_vec_t                       last_nx;
    tag_vec_t                       fin;
    tag_vec_t                       done_pend;
    tag_vec_t                       grant;
    logic [TAG_W-1:0]               rr_ptr;

    always_comb begin
        for (int t = 0; t < NUM_TAGS; t++) begin
            logic inc;
            inc      = acc_en && (acc_tag == TAG_W'(t));
            dec_n[t] = '0;
            for (int c = 0; c < NUM_CHIPS; c++) begin
                if (ack_hit[c] && (ack_tag[c] == TAG_W'(t))) dec_n[t] = dec_n[t] + CNT_W'(1);
            end
            cnt_nx[t]  = cnt[t] + CNT_W'(inc) - dec_n[t];
            last_nx[t] = last_seen[t] || (inc && acc_last);
            fin[t]     = last_nx[t] && (cnt_nx[t] == '0);
        end
    end

    assign grant      = rr_pick(done_pend, rr_ptr);
    assign done_valid = |done_pend;
    assign done_tag   = tag_index(grant);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            last_seen <= '0;
            done_pend <= '0;
            rr_ptr    <= '0;
        end else begin
            cnt       <= cnt_nx;
            last_seen <= last_nx & ~fin;
            done_pend <= (done_pend & ~grant) | fin;
            if (done_valid) rr_ptr <= done_tag + TAG_W'(1);
        end
    end

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (cnt[done_tag] == '0)); // R8

    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !(done_valid && (done_tag == $past(done_tag)))); // R9

    genvar t;
    generate
        for (t = 0; t < NUM_TAGS; t++) begin : g_tag_chk
            AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
                dec_n[t] <= cnt[t]); // R7
        end
    endgenerate

endmodule

// File: rtl/flash_rsched.sv
module flash_rsched
    import frs_pkg::*;
(
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 in_valid,
    output logic                                 in_ready,
    input  logic [CHIP_W-1:0]                    in_chip,
    input  logic [DIE_W-1:0]                     in_die,
    input  logic [PLANE_W-1:0]                   in_plane,
    input  logic [1:0]                           in_op,
    input  logic [TAG_W-1:0]                     in_tag,
    input  logic                                 in_last,
    input  logic [NUM_CHIPS-1:0]                 chip_rdy,
    input  logic [NUM_CHIPS-1:0]                 chip_ack,
    output logic [NUM_CHIPS-1:0]                 cmd_valid,
    output logic [NUM_CHIPS-1:0][DIE_W-1:0]      cmd_die,
    output logic [NUM_CHIPS-1:0][PLANE_W-1:0]    cmd_plane,
    output logic [NUM_CHIPS-1:0][1:0]            cmd_op,
    output logic [NUM_CHIPS-1:0][TAG_W-1:0]      cmd_tag,
    output logic                                 done_valid,
    output logic [TAG_W-1:0]                     done_tag
);

    logic                             in_fire;
    mreq_t                            wr_req;
    pool_vec_t                        valid;
    mreq_t [POOL_DEPTH-1:0]           entries;
    age_mat_t                         older;
    pool_vec_t                        free_mask;
    mreq_t [NUM_CHIPS-1:0]            cmd_req;
    logic [NUM_CHIPS-1:0]             ack_hit;
    logic [NUM_CHIPS-1:0][TAG_W-1:0]  ack_tag;

    assign in_fire = in_valid && in_ready;

    always_comb begin
        wr_req.chip  = in_chip;
        wr_req.die   = in_die;
        wr_req.plane = in_plane;
        wr_req.op    = flash_op_e'(in_op);
        wr_req.tag   = in_tag;
    end

    frs_req_pool u_pool (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (in_fire),
        .wr_req    (wr_req),
        .free_mask (free_mask),
        .valid     (valid),
        .entries   (entries),
        .older     (older),
        .has_room  (in_ready)
    );

    frs_chip_dispatch u_disp (
        .clk       (clk),
        .rst       (rst),
        .valid     (valid),
        .entries   (entries),
        .older     (older),
        .chip_rdy  (chip_rdy),
        .chip_ack  (chip_ack),
        .cmd_valid (cmd_valid),
        .cmd_req   (cmd_req),
        .free_mask (free_mask),
        .ack_hit   (ack_hit),
        .ack_tag   (ack_tag)
    );

    frs_tag_tracker u_tags (
        .clk        (clk),
        .rst        (rst),
        .acc_en     (in_fire),
        .acc_tag    (in_tag),
        .acc_last   (in_last),
        .ack_hit    (ack_hit),
        .ack_tag    (ack_tag),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CHIPS; c++) begin : g_out
            assign cmd_die[c]   = cmd_req[c].die;
            assign cmd_plane[c] = cmd_req[c].plane;
            assign cmd_op[c]    = cmd_req[c].op;
            assign cmd_tag[c]   = cmd_req[c].tag;

            AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
                !chip_rdy[c] |-> !cmd_valid[c]); // R4
        end
    endgenerate

endmodule

// File: tb/flash_rsched_tb.sv
`timescale 1ns/1ps
module flash_rsched_tb;
    import frs_pkg::*;

    logic                               clk = 1'b0;
    logic                               rst;
    logic                               in_valid;
    logic                               in_ready;
    logic [CHIP_W-1:0]                  in_chip;
    logic [DIE_W-1:0]                   in_die;
    logic [PLANE_W-1:0]                 in_plane;
    logic [1:0]                         in_op;
    logic [TAG_W-1:0]                   in_tag;
    logic                               in_last;
    logic [NUM_CHIPS-1:0]               chip_rdy;
    logic [NUM_CHIPS-1:0]               chip_ack;
    logic [NUM_CHIPS-1:0]               cmd_valid;
    logic [NUM_CHIPS-1:0][DIE_W-1:0]    cmd_die;
    logic [NUM_CHIPS-1:0][PLANE_W-1:0]  cmd_plane;
    logic [NUM_CHIPS-1:0][1:0]          cmd_op;
    logic [NUM_CHIPS-1:0][TAG_W-1:0]    cmd_tag;
    logic                               done_valid;
    logic [TAG_W-1:0]                   done_tag;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    flash_rsched u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_chip(in_chip), .in_die(in_die), .in_plane(in_plane),
        .in_op(in_op), .in_tag(in_tag), .in_last(in_last),
        .chip_rdy(chip_rdy), .chip_ack(chip_ack),
        .cmd_valid(cmd_valid), .cmd_die(cmd_die), .cmd_plane(cmd_plane),
        .cmd_op(cmd_op), .cmd_tag(cmd_tag),
        .done_valid(done_valid), .done_tag(done_tag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Offer one request at a falling edge; returns at the next falling edge.
    task automatic push(input int chip, input int die, input int plane,
                        input int op, input int tag, input bit last);
        in_chip  = CHIP_W'(chip);
        in_die   = DIE_W'(die);
        in_plane = PLANE_W'(plane);
        in_op    = 2'(op);
        in_tag   = TAG_W'(tag);
        in_last  = last;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic t_reset();
        rst      = 1'b1;
        in_valid = 1'b0;
        in_chip  = '0;
        in_die   = '0;
        in_plane = '0;
        in_op    = '0;
        in_tag   = '0;
        in_last  = 1'b0;
        chip_rdy = '0;
        chip_ack = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "in_ready", int'(in_ready), 1);
        chk("R1", "cmd_valid", int'(cmd_valid), 0);
        chk("R1", "done_valid", int'(done_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_basic();
        chip_rdy = 4'hF;
        push(2, 1, 3, 1, 5, 1'b1);
        #1;
        chk("R3", "cmd_valid", int'(cmd_valid), 4'b0100);
        chk("R3", "cmd_die", int'(cmd_die[2]), 1);
        chk("R3", "cmd_plane", int'(cmd_plane[2]), 3);
        chk("R3", "cmd_op", int'(cmd_op[2]), 1);
        chk("R3", "cmd_tag", int'(cmd_tag[2]), 5);
        @(negedge clk); #1;
        chk("R7", "no reissue", int'(cmd_valid), 0);
        chk("R8", "no early done", int'(done_valid), 0);
        chip_ack = 4'b0100;
        @(negedge clk);
        chip_ack = '0;
        #1;
        chk("R8", "done_valid", int'(done_valid), 1);
        chk("R8", "done_tag", int'(done_tag), 5);
        @(negedge clk); #1;
        chk("R8", "done one cycle", int'(done_valid), 0);
        @(negedge clk);
    endtask

    task automatic t_busy_chip();
        chip_rdy = 4'b1101;
        push(1, 0, 0, 0, 1, 1'b0);
        #1 chk("R4", "busy chip1 after push", int'(cmd_valid[1]), 0);
        push(1, 1, 2, 0, 1, 1'b1);
        #1 chk("R4", "busy chip1 after push2", int'(cmd_valid[1]), 0);
        push(3, 0, 1, 2, 2, 1'b1);
        #1;
        chk("R5", "chip3 served past busy chip1", int'(cmd_valid), 4'b1000);
        chk("R5", "chip3 tag", int'(cmd_tag[3]), 2);
        chk("R5", "chip3 op", int'(cmd_op[3]), 2);
        @(negedge clk);
        chip_ack = 4'b1000;
        #1 chk("R4", "chip1 still silent", int'(cmd_valid), 0);
        @(negedge clk);
        chip_ack = '0;
        #1;
        chk("R8", "tag2 done", int'(done_valid), 1);
        chk("R8", "tag2 value", int'(done_tag), 2);
        chip_rdy = 4'hF;
        #0.5;
        chk("R6", "chip1 oldest valid", int'(cmd_valid), 4'b0010);
        chk("R6", "chip1 oldest plane", int'(cmd_plane[1]), 0);
        chk("R6", "chip1 oldest die", int'(cmd_die[1]), 0);
        @(negedge clk); #1;
        chk("R7", "chip1 locked", int'(cmd_valid), 0);
        chip_ack = 4'b0010;
        @(negedge clk);
        chip_ack = '0;
        #1;
        chk("R8", "tag1 not yet done", int'(done_valid), 0);
        chk("R6", "chip1 second valid", int'(cmd_valid), 4'b0010);
        chk("R6", "chip1 second plane", int'(cmd_plane[1]), 2);
        @(negedge clk); #1;
        chip_ack = 4'b0010;
        @(negedge clk);
        chip_ack = '0;
        #1;
        chk("R8", "tag1 done", int'(done_valid), 1);
        chk("R8", "tag1 value", int'(done_tag), 1);
        @(negedge clk);
    endtask

    task automatic t_stray_ack();
        chip_rdy = 4'hF;
        push(1, 0, 0, 1, 7, 1'b0);
        push(0, 0, 0, 1, 7, 1'b0);
        push(0, 1, 1, 1, 7, 1'b1);
        chip_ack = 4'b0010;
        @(negedge clk);
        chip_ack = 4'b0010;
        #1;
        chk("R7", "chip0 locked", int'(cmd_valid), 0);
        chk("R7", "no done on stray", int'(done_valid), 0);
        @(negedge clk);
        chip_ack = 4'b0001;
        @(negedge clk);
        chip_ack = '0;
        #1;
        chk("R7", "stray ack ignored: no done", int'(done_valid), 0);
        chk("R7", "chip0 next valid", int'(cmd_valid), 4'b0001);
        chk("R7", "chip0 next plane", int'(cmd_plane[0]), 1);
        @(negedge clk);
        chip_ack = 4'b0001;
        @(negedge clk);
        chip_ack = '0;
        #1;
        chk("R8", "tag7 done", int'(done_valid), 1);
        chk("R8", "tag7 value", int'(done_tag), 7);
        @(negedge clk);
    endtask

    task automatic t_full_pool();
        int n;
        int done8;
        logic [NUM_CHIPS-1:0] prev;
        logic [NUM_CHIPS-1:0] cur;
        chip_rdy = '0;
        for (int i = 0; i < POOL_DEPTH; i++) begin
            #1 chk("R2", "ready before fill", int'(in_ready), 1);
            push(i % NUM_CHIPS, i % 2, i % 4, 0, 8, (i == POOL_DEPTH - 1));
        end
        #1 chk("R2", "ready low when full", int'(in_ready), 0);
        in_chip  = '0;
        in_tag   = TAG_W'(9);
        in_last  = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #1;
        chk("R2", "still full", int'(in_ready), 0);
        chk("R4", "all busy silent", int'(cmd_valid), 0);
        chip_rdy = 4'hF;
        #0.5;
        chk("R10", "all chips issue together", int'(cmd_valid), 4'hF);
        n     = $countones(cmd_valid);
        done8 = 0;
        prev  = cmd_valid;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chip_ack = prev;
            #1;
            cur = cmd_valid;
            for (int c = 0; c < NUM_CHIPS; c++) begin
                if (cur[c]) chk("R2", "dispatched tag", int'(cmd_tag[c]), 8);
            end
            n = n + $countones(cur);
            if (done_valid) begin
                done8++;
                chk("R8", "full-pool done tag", int'(done_tag), 8);
            end
            prev = cur;
        end
        chip_ack = '0;
        chk("R2", "dispatch count", n, POOL_DEPTH);
        chk("R8", "tag8 done count", done8, 1);
        chk("R2", "ready after drain", int'(in_ready), 1);
        @(negedge clk);
    endtask

    task automatic t_multi_done();
        logic [2:0] seen;
        chip_rdy = 4'hF;
        push(0, 0, 0, 0, 10, 1'b1);
        push(1, 0, 0, 0, 11, 1'b1);
        push(2, 0, 0, 0, 12, 1'b1);
        @(negedge clk);
        chip_ack = 4'b0111;
        @(negedge clk);
        chip_ack = '0;
        seen = '0;
        for (int k = 0; k < 3; k++) begin
            if (k > 0) @(negedge clk);
            #1;
            chk("R9", "consecutive done", int'(done_valid), 1);
            if (done_valid && done_tag >= 10 && done_tag <= 12) begin
                chk("R9", "tag reported once", int'(seen[done_tag - 10]), 0);
                seen[done_tag - 10] = 1'b1;
            end
        end
        @(negedge clk); #1;
        chk("R9", "done ends", int'(done_valid), 0);
        chk("R9", "all three reported", int'(seen), 3'b111);
        @(negedge clk);
    endtask

    initial begin
        #(5ns * 100000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_busy_chip();
        t_stray_ack();
        t_full_pool();
        t_multi_done();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule